// File: doc/BRIEF.md
# Flash command and status controller

This block is the command front end of a byte-wide flash device. Bus writes carry command bytes. The block uses them to pick what a read returns: the array, the status byte or the identifier codes. It also runs sector erase and byte program as two-write sequences. Each operation holds the device busy for a fixed number of clock cycles. During that time it can be suspended and later resumed.

The storage is a small behavioural byte memory split into equal sectors. The array's supply check is reduced to one input that says whether the programming voltage is valid. A per-sector lock input vetoes changes to the sectors it covers. Status error flags are sticky. Only the internal sequencer sets them, and only the clear command resets them. A ready output follows the status ready bit, so a host can poll the pin instead of reading status.

Top module: `flash_cui`

## Requirements
- R1: After reset, ready_o is 1, reads return array data, every array byte reads FFh, and the status byte reads 80h.
- R2: Command FFh selects array reads, 70h selects status reads and 90h selects identifier reads. In identifier mode, address 0 returns MFR_CODE, address 1 returns DEV_CODE and any other address returns 00h. Each command takes effect on the clock edge that captures the write.
- R3: Write 20h, then write D0h at an address in the target sector. If the supply is valid and the sector is unlocked, ready_o is 0 for exactly BUSY_CYC cycles. Every byte of that sector then reads FFh, and all other sectors keep their contents. After the setup write, reads return status.
- R4: Write 40h or 10h, then write an address and a data byte. Once the busy time ends, that byte holds the old value AND the data, so bits only go from 1 to 0.
- R5: If the second write of an erase sequence is not D0h, nothing is erased. The device stays ready, and status bits 5 (erase error) and 4 (program error) are set.
- R6: If vpp_ok_i is 0 when an erase or program would start, status bit 3 is set. The device does not go busy and the array is unchanged.
- R7: If an erase or program targets a sector whose lock_i bit is 1, status bit 1 is set. The device does not go busy and the array is unchanged. Sector index is the top SECT_W address bits.
- R8: Error bits 5, 4, 3 and 1 stay set through every other command. Writing 50h while idle clears all four.
- R9: Writing B0h while busy suspends the operation and ready_o goes to 1. Status bit 6 is then set for a suspended erase, or bit 2 for a suspended program. Array reads return the contents from before the operation. Writing D0h resumes the operation, and it completes the remaining busy cycles.
- R10: The status byte is {ready, erase-suspended, erase-error, program-error, vpp-error, program-suspended, lock-error, 0}. Bit 0 always reads 0, and ready_o always equals bit 7.
- R11: While busy, every write other than B0h and 70h is ignored. Reads keep returning status and the operation still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | ADDR_W | Byte address for writes and reads |
| wdata_i | input | 8 | Command or program data byte |
| vpp_ok_i | input | 1 | Programming supply valid |
| lock_i | input | 2**SECT_W | Per-sector write lock |
| rdata_o | output | 8 | Read data for addr_i in the current read mode |
| ready_o | output | 1 | 1 when no operation is running (status bit 7) |

## Verification
The assertions assume each bus write lasts a single cycle. They also assume vpp_ok_i and lock_i are steady at the edge where an operation starts, and that no suspend write lands on the edge that ends the busy time. The bench drives one write per task call, aligned to the falling edge. It changes the supply and lock inputs only while the device is idle. It places each suspend a couple of cycles into the busy time, well before the end, so the stimulus stays inside these assumptions. Random sequences mix erase, program and clear with occasional bad supply, locked sectors and wrong confirm bytes, and a bench-side model tracks them.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;
  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_IDENT} rd_mode_e;
  typedef enum logic [2:0] {ST_IDLE, ST_ERS_SETUP, ST_PRG_SETUP, ST_BUSY, ST_SUSP} cui_state_e;

  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_RD_STATUS = 8'h70;
  localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_CLR_ERR   = 8'h50;
  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_PROG_A    = 8'h40;
  localparam logic [7:0] CMD_PROG_B    = 8'h10;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND   = 8'hB0;

  localparam int SB_READY    = 7;
  localparam int SB_ERS_SUSP = 6;
  localparam int SB_ERS_ERR  = 5;
  localparam int SB_PRG_ERR  = 4;
  localparam int SB_VPP_ERR  = 3;
  localparam int SB_PRG_SUSP = 2;
  localparam int SB_LOCK_ERR = 1;
endpackage

// File: rtl/flash_cui_cmd.sv
module flash_cui_cmd
  import flash_cui_pkg::*;
#(
  parameter int AW       = 6,
  parameter int SW       = 2,
  parameter int BUSY_CYC = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 vpp_ok_i,
  input  logic [(1<<SW)-1:0]   lock_i,
  output cui_state_e           state_o,
  output rd_mode_e             mode_o,
  output logic [7:0]           status_o,
  output logic                 erase_go_o,
  output logic                 prog_go_o,
  output logic [AW-1:0]        op_addr_o,
  output logic [7:0]           op_data_o
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  cui_state_e     state_q;
  rd_mode_e       mode_q;
  logic [CW-1:0]  cnt_q;
  logic           op_erase_q;
  logic [AW-1:0]  op_addr_q;
  logic [7:0]     op_data_q;
  logic           ers_err_q, prg_err_q, vpp_err_q, lock_err_q;

  logic [SW-1:0]  sect;
  logic           locked, susp_wr, done;

  assign sect    = addr_i[AW-1 -: SW];
  assign locked  = lock_i[sect];
  assign susp_wr = we_i && (wdata_i == CMD_SUSPEND);
  assign done    = (state_q == ST_BUSY) && (cnt_q == CW'(1)) && !susp_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= RD_ARRAY;
      cnt_q      <= '0;
      op_erase_q <= 1'b0;
      op_addr_q  <= '0;
      op_data_q  <= '0;
      ers_err_q  <= 1'b0;
      prg_err_q  <= 1'b0;
      vpp_err_q  <= 1'b0;
      lock_err_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (we_i) begin
          unique case (wdata_i)
            CMD_RD_ARRAY:  mode_q <= RD_ARRAY;
            CMD_RD_STATUS: mode_q <= RD_STATUS;
            CMD_RD_IDENT:  mode_q <= RD_IDENT;
            CMD_CLR_ERR: begin
              ers_err_q  <= 1'b0;
              prg_err_q  <= 1'b0;
              vpp_err_q  <= 1'b0;
              lock_err_q <= 1'b0;
            end
            CMD_ERASE: begin
              state_q <= ST_ERS_SETUP;
              mode_q  <= RD_STATUS;
            end
            CMD_PROG_A, CMD_PROG_B: begin
              state_q <= ST_PRG_SETUP;
              mode_q  <= RD_STATUS;
            end
            default: ;
          endcase
        end
        ST_ERS_SETUP, ST_PRG_SETUP: if (we_i) begin
          op_erase_q <= (state_q == ST_ERS_SETUP);
          op_addr_q  <= addr_i;
          op_data_q  <= wdata_i;
          mode_q     <= RD_STATUS;
          state_q    <= ST_IDLE;
          if (state_q == ST_ERS_SETUP && wdata_i != CMD_CONFIRM) begin
            // wrong confirm byte: sequence error
            ers_err_q <= 1'b1;
            prg_err_q <= 1'b1;
          end else if (!vpp_ok_i) begin
            vpp_err_q <= 1'b1;
          end else if (locked) begin
            lock_err_q <= 1'b1;
          end else begin
            state_q <= ST_BUSY;
            cnt_q   <= CW'(BUSY_CYC);
          end
        end
        ST_BUSY: begin
          if (susp_wr) begin
            state_q <= ST_SUSP;
          end else begin
            if (we_i && wdata_i == CMD_RD_STATUS) mode_q <= RD_STATUS;
            if (done) state_q <= ST_IDLE;
            else      cnt_q   <= cnt_q - CW'(1);
          end
        end
        ST_SUSP: if (we_i) begin
          unique case (wdata_i)
            CMD_RD_ARRAY:  mode_q <= RD_ARRAY;
            CMD_RD_STATUS: mode_q <= RD_STATUS;
            CMD_RD_IDENT:  mode_q <= RD_IDENT;
            CMD_CONFIRM: begin
              state_q <= ST_BUSY;
              mode_q  <= RD_STATUS;
            end
            default: ;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    status_o              = '0;
    status_o[SB_READY]    = (state_q != ST_BUSY);
    status_o[SB_ERS_SUSP] = (state_q == ST_SUSP) && op_erase_q;
    status_o[SB_ERS_ERR]  = ers_err_q;
    status_o[SB_PRG_ERR]  = prg_err_q;
    status_o[SB_VPP_ERR]  = vpp_err_q;
    status_o[SB_PRG_SUSP] = (state_q == ST_SUSP) && !op_erase_q;
    status_o[SB_LOCK_ERR] = lock_err_q;
  end

  assign state_o    = state_q;
  assign mode_o     = mode_q;
  assign erase_go_o = done && op_erase_q;
  assign prog_go_o  = done && !op_erase_q;
  assign op_addr_o  = op_addr_q;
  assign op_data_o  = op_data_q;
endmodule

// File: rtl/flash_cui_array.sv
module flash_cui_array #(
  parameter int AW = 6,
  parameter int SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_i,
  input  logic          prog_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic [7:0]    op_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  localparam int DEPTH = 1 << AW;
  localparam int SSH   = AW - SW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (erase_i && op_addr_i[AW-1 -: SW] == SW'(i >> SSH))
          mem_q[i] <= 8'hFF;
        else if (prog_i && op_addr_i == AW'(i))
          mem_q[i] <= mem_q[i] & op_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/flash_cui_rdmux.sv
module flash_cui_rdmux
  import flash_cui_pkg::*;
#(
  parameter int         AW  = 6,
  parameter logic [7:0] MFR = 8'hA5,
  parameter logic [7:0] DEV = 8'h3C
) (
  input  rd_mode_e      mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    arr_i,
  input  logic [7:0]    status_i,
  output logic [7:0]    rdata_o
);
  always_comb begin
    unique case (mode_i)
      RD_STATUS: rdata_o = status_i;
      RD_IDENT: begin
        if (addr_i == AW'(0))      rdata_o = MFR;
        else if (addr_i == AW'(1)) rdata_o = DEV;
        else                       rdata_o = 8'h00;
      end
      default:   rdata_o = arr_i;
    endcase
  end
endmodule

// File: rtl/flash_cui.sv
module flash_cui
  import flash_cui_pkg::*;
#(
  parameter int         ADDR_W   = 6,
  parameter int         SECT_W   = 2,
  parameter int         BUSY_CYC = 8,
  parameter logic [7:0] MFR_CODE = 8'hA5,
  parameter logic [7:0] DEV_CODE = 8'h3C
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [7:0]               wdata_i,
  input  logic                     vpp_ok_i,
  input  logic [(1<<SECT_W)-1:0]   lock_i,
  output logic [7:0]               rdata_o,
  output logic                     ready_o
);
  cui_state_e        cui_state;
  rd_mode_e          rd_mode;
  logic [7:0]        status_byte;
  logic              erase_go, prog_go;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data, arr_data;

  flash_cui_cmd #(.AW(ADDR_W), .SW(SECT_W), .BUSY_CYC(BUSY_CYC)) u_cmd (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .vpp_ok_i, .lock_i,
    .state_o(cui_state), .mode_o(rd_mode), .status_o(status_byte),
    .erase_go_o(erase_go), .prog_go_o(prog_go),
    .op_addr_o(op_addr), .op_data_o(op_data)
  );

  flash_cui_array #(.AW(ADDR_W), .SW(SECT_W)) u_array (
    .clk_i, .rst_ni, .erase_i(erase_go), .prog_i(prog_go),
    .op_addr_i(op_addr), .op_data_i(op_data),
    .rd_addr_i(addr_i), .rd_data_o(arr_data)
  );

  flash_cui_rdmux #(.AW(ADDR_W), .MFR(MFR_CODE), .DEV(DEV_CODE)) u_rdmux (
    .mode_i(rd_mode), .addr_i, .arr_i(arr_data), .status_i(status_byte),
    .rdata_o
  );

  assign ready_o = status_byte[SB_READY];
endmodule

// File: rtl/flash_cui_chk.sv
module flash_cui_chk
  import flash_cui_pkg::*;
#(
  parameter int AW = 6,
  parameter int SW = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [AW-1:0]      addr_i,
  input logic [7:0]         wdata_i,
  input logic               vpp_ok_i,
  input logic [(1<<SW)-1:0] lock_i,
  input logic [7:0]         rdata_o,
  input logic               ready_o,
  input cui_state_e         state,
  input rd_mode_e           mode,
  input logic [7:0]         status
);
  logic [SW-1:0] sect;
  logic          clr_wr, start_ok, start_try;
  assign sect      = addr_i[AW-1 -: SW];
  assign clr_wr    = we_i && wdata_i == CMD_CLR_ERR && state == ST_IDLE;
  assign start_try = we_i && ((state == ST_ERS_SETUP && wdata_i == CMD_CONFIRM) ||
                              state == ST_PRG_SETUP);
  assign start_ok  = start_try && vpp_ok_i && !lock_i[sect];

  assert_start_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok |=> !ready_o);

  assert_bad_confirm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && state == ST_ERS_SETUP && wdata_i != CMD_CONFIRM)
    |=> (ready_o && status[SB_ERS_ERR] && status[SB_PRG_ERR]));

  assert_vpp_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_try && !vpp_ok_i) |=> (ready_o && status[SB_VPP_ERR]));

  assert_lock_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_try && vpp_ok_i && lock_i[sect]) |=> (ready_o && status[SB_LOCK_ERR]));

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[SB_ERS_ERR] && !clr_wr) |=> status[SB_ERS_ERR]);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> (status[5:3] == 3'b000 && !status[SB_LOCK_ERR]));

  assert_suspend_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_BUSY && we_i && wdata_i == CMD_SUSPEND)
    |=> (ready_o && (status[SB_ERS_SUSP] || status[SB_PRG_SUSP])));

  assert_status_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == RD_STATUS) |-> (rdata_o == status && !rdata_o[0] && rdata_o[7] == ready_o));

  assert_busy_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_BUSY && we_i && wdata_i != CMD_SUSPEND) |=> (mode == RD_STATUS));
endmodule

bind flash_cui flash_cui_chk #(.AW(ADDR_W), .SW(SECT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .vpp_ok_i(vpp_ok_i), .lock_i(lock_i),
  .rdata_o(rdata_o), .ready_o(ready_o),
  .state(cui_state), .mode(rd_mode), .status(status_byte)
);

// File: tb/flash_cui_test.sv
module flash_cui_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NB = 1 << AW;
  localparam int BC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic          vpp = 1'b1;
  logic [3:0]    lock = '0;
  logic [7:0]    rdata;
  logic          ready;

  flash_cui #(.ADDR_W(AW), .SECT_W(2), .BUSY_CYC(BC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .vpp_ok_i(vpp), .lock_i(lock), .rdata_o(rdata), .ready_o(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] refm [NB];
  bit e_err, p_err, v_err, l_err;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_st(input bit rdy, input bit es, input bit ps);
    return {rdy, es, e_err, p_err, v_err, ps, l_err, 1'b0};
  endfunction

  function automatic logic [1:0] sect_of(input logic [AW-1:0] a);
    return a[AW-1 -: 2];
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
    @(negedge clk);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_status(input string req);
    logic [7:0] d;
    wr(0, 8'h70);
    rd(0, d);
    check(req, d, exp_st(1'b1, 1'b0, 1'b0));
    check({req, " pin"}, ready, 1);
  endtask

  task automatic check_mem(input string req);
    logic [7:0] d;
    int miss = 0;
    wr(0, 8'hFF);
    for (int i = 0; i < NB; i++) begin
      rd(AW'(i), d);
      if (d !== refm[i]) miss++;
    end
    check(req, miss, 0);
  endtask

  task automatic ref_erase(input logic [AW-1:0] a);
    for (int i = 0; i < NB; i++)
      if (sect_of(AW'(i)) == sect_of(a)) refm[i] = 8'hFF;
  endtask

  task automatic do_erase(input logic [AW-1:0] a, input logic [7:0] conf, input bit chk_len);
    int n;
    wr(a, 8'h20);
    wr(a, conf);
    if (conf != 8'hD0) begin
      e_err = 1; p_err = 1;
      check("R5 ready after bad confirm", ready, 1);
    end else if (!vpp) begin
      v_err = 1;
      check("R6 no busy on bad vpp", ready, 1);
    end else if (lock[sect_of(a)]) begin
      l_err = 1;
      check("R7 no busy on locked sector", ready, 1);
    end else begin
      check("R3 busy after confirm", ready, 0);
      wait_ready(n);
      if (chk_len) check("R3 busy length", n, BC);
      ref_erase(a);
    end
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d, input logic [7:0] setup);
    int n;
    wr(a, setup);
    wr(a, d);
    if (!vpp) begin
      v_err = 1;
      check("R6 no busy on bad vpp", ready, 1);
    end else if (lock[sect_of(a)]) begin
      l_err = 1;
      check("R7 no busy on locked sector", ready, 1);
    end else begin
      check("R4 busy after program", ready, 0);
      wait_ready(n);
      check("R4 program length", n, BC);
      refm[a] = refm[a] & d;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    void'($urandom(32'h5eed_0c01));
    for (int i = 0; i < NB; i++) refm[i] = 8'hFF;
    e_err = 0; p_err = 0; v_err = 0; l_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ready at reset", ready, 1);
    rd(6'd5, d);
    check("R1 array mode after reset", d, 8'hFF);
    check_mem("R1 erased array");
    check_status("R1 status after reset");

    // R2 read modes and identifier
    wr(0, 8'h90);
    rd(0, d); check("R2 manufacturer code", d, 8'hA5);
    rd(1, d); check("R2 device code", d, 8'h3C);
    rd(2, d); check("R2 other id offset", d, 8'h00);
    wr(0, 8'h70);
    rd(9, d); check("R2 status mode", d, 8'h80);
    wr(0, 8'hFF);
    rd(9, d); check("R2 array mode", d, 8'hFF);

    // R4 program both setup codes, 1->0 only
    do_prog(6'h12, 8'hA5, 8'h40);
    do_prog(6'h12, 8'h5A, 8'h10);
    do_prog(6'h23, 8'h0F, 8'h40);
    check_mem("R4 bits only cleared");
    wr(0, 8'hFF);
    rd(6'h12, d); check("R4 programmed byte", d, 8'h00);

    // R3 erase sector 1, others kept
    do_erase(6'h15, 8'hD0, 1);
    check_mem("R3 sector erased others kept");

    // R5 bad confirm + R8 stickiness through other commands
    do_prog(6'h31, 8'h11, 8'h40);
    do_erase(6'h30, 8'h33, 0);
    check_mem("R5 nothing erased");
    wr(0, 8'hFF);
    wr(0, 8'h90);
    check_status("R8 errors sticky");
    wr(0, 8'h50);
    e_err = 0; p_err = 0;
    check_status("R8 cleared by 50h");

    // R6 vpp low
    vpp = 1'b0;
    do_prog(6'h01, 8'h00, 8'h40);
    do_erase(6'h23, 8'hD0, 0);
    vpp = 1'b1;
    check_mem("R6 array unchanged");
    check_status("R6 vpp flag");

    // R7 locked sector
    lock = 4'b0100;
    do_erase(6'h23, 8'hD0, 0);
    do_prog(6'h2A, 8'h00, 8'h10);
    check_mem("R7 array unchanged");
    check_status("R7 lock flag");
    lock = 4'b0000;
    wr(0, 8'h50);
    v_err = 0; l_err = 0;
    check_status("R8 all flags cleared");

    // R9 erase suspend/resume
    wr(6'h20, 8'h20);
    wr(6'h20, 8'hD0);
    wr(0, 8'hB0);
    check("R9 ready while suspended", ready, 1);
    rd(0, d); check("R9 erase suspend status", d, exp_st(1'b1, 1'b1, 1'b0));
    wr(0, 8'hFF);
    rd(6'h23, d); check("R9 array readable in suspend", d, refm[6'h23]);
    wr(0, 8'hD0);
    check("R9 busy after resume", ready, 0);
    wait_ready(n);
    ref_erase(6'h20);
    check_mem("R9 erase completed after resume");

    // R9 program suspend/resume
    wr(6'h07, 8'h40);
    wr(6'h07, 8'h3C);
    wr(0, 8'hB0);
    check("R9 ready in program suspend", ready, 1);
    rd(0, d); check("R9 program suspend status", d, exp_st(1'b1, 1'b0, 1'b1));
    wr(0, 8'hD0);
    wait_ready(n);
    refm[6'h07] = refm[6'h07] & 8'h3C;
    check_mem("R9 program completed after resume");

    // R11 writes ignored while busy, R10 status during busy
    wr(6'h09, 8'h40);
    wr(6'h09, 8'hF0);
    wr(0, 8'hFF);
    wr(0, 8'h90);
    wr(0, 8'h20);
    rd(0, d);
    check("R10 busy status byte", d, exp_st(1'b0, 1'b0, 1'b0));
    check("R10 pin matches bit7", ready, d[7]);
    wait_ready(n);
    rd(0, d);
    check("R11 still status mode", d, exp_st(1'b1, 1'b0, 1'b0));
    refm[6'h09] = refm[6'h09] & 8'hF0;
    check_mem("R11 program completed");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op;
      logic [AW-1:0] a;
      op = int'($urandom % 4);
      a = AW'($urandom);
      vpp = ($urandom % 5) != 0;
      lock = 4'($urandom) & 4'($urandom);
      case (op)
        0: do_erase(a, (($urandom % 6) == 0) ? 8'h77 : 8'hD0, 1);
        1: do_prog(a, 8'($urandom), 8'h40);
        2: do_prog(a, 8'($urandom), 8'h10);
        default: begin
          wr(0, 8'h50);
          e_err = 0; p_err = 0; v_err = 0; l_err = 0;
        end
      endcase
      vpp = 1'b1; lock = '0;
      check_status("R8 random status");
      check_mem("R3 random array");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule